// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block holds the register and control logic of a successive approximation converter. A single-cycle start request begins a conversion. The sequencer places a trial code on its DAC output with one new bit set, lets the external analog path settle for a programmable number of cycles, then reads the comparator decision to keep or drop that bit. It works from the most significant bit down to the least significant one.

When the last bit has been decided, the finished code moves into a separate output register. That register keeps its value until the next conversion completes. The result is given as plain binary for single-polarity inputs. For signed inputs it is given as two's complement, which places the signed zero at mid-scale. The polarity selection is captured when the conversion starts. The DAC and comparator are outside the block.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, `busy` and `done` are low, and `result` and `dac_code` are zero.
- R2: A `start` sampled high while the block is idle raises `busy` on the next cycle. The first trial code is then the most significant bit alone (bit WIDTH-1 set, all others clear).
- R3: Each trial code is held for SETTLE+1 cycles, and the comparator is sampled on the last of those cycles. Bits are decided from WIDTH-1 down to 0. `done` therefore rises WIDTH*(SETTLE+1) cycles after the cycle in which `busy` first reads high.
- R4: A high `cmp_hi` at a bit's decision keeps that bit set; a low `cmp_hi` clears it. With `bipolar` low, the result equals the ideal quantisation of the input: the largest code whose DAC level does not exceed the input.
- R5: `done` is high for exactly one cycle per conversion. It never coincides with `busy`, and it marks the cycle in which `result` takes its new value.
- R6: `result` does not change at any time other than a `done` cycle, whatever `cmp_hi` and `bipolar` do in between.
- R7: A `start` asserted while `busy` is high has no effect: the running conversion keeps its timing and its result.
- R8: With `bipolar` high at the start cycle, `result` is the decided code with bit WIDTH-1 inverted (two's complement, mid-scale maps to zero). Changes of `bipolar` during a conversion do not affect that conversion.
- R9: The width (WIDTH, for example 12 or 16) and the settle count (SETTLE) are parameters, and all timing and codes scale with them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled when idle |
| bipolar | input | 1 | 1 selects two's complement output, 0 plain binary |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is above the trial level |
| dac_code | output | WIDTH | Trial code driven to the external DAC |
| busy | output | 1 | High while a conversion is running |
| done | output | 1 | One-cycle completion strobe |
| result | output | WIDTH | Latched conversion result |

## Verification
Most internal faults in this block show up first on `dac_code`. If the bit pointer, the settle counter or the trial register goes wrong, the trial sequence departs from the expected staircase within one step of SETTLE+1 cycles, long before any result is produced. A wrong decision or a faulty recoding shows only at `result` on the `done` cycle of that conversion. A fault in the hand-off between control and latch shows up as a wrong `done` time, or as `result` moving outside a `done` cycle. The bench therefore compares the trial sequence, the latency and the result of every conversion in a small exhaustive configuration against arithmetic made in the bench.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_TRIAL = 1'b1
    } seq_state_e;

endpackage

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
    parameter int WIDTH  = 16,
    parameter int SETTLE = 2,
    parameter int IW     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          init,
    output logic          decide,
    output logic          last,
    output logic [IW-1:0] bit_idx
);
    import sar_pkg::*;

    localparam int CW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
    localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE);
    localparam logic [IW-1:0] TOP_IDX    = IW'(WIDTH - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        init   = 1'b0;
        decide = 1'b0;
        last   = 1'b0;
        unique case (ctrl_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    ctrl_d.state = SEQ_TRIAL;
                    ctrl_d.cnt   = '0;
                    ctrl_d.idx   = TOP_IDX;
                    init         = 1'b1;
                end
            end
            SEQ_TRIAL: begin
                if (ctrl_q.cnt == SETTLE_END) begin
                    decide     = 1'b1;
                    ctrl_d.cnt = '0;
                    if (ctrl_q.idx == '0) begin
                        last         = 1'b1;
                        ctrl_d.state = SEQ_IDLE;
                    end else begin
                        ctrl_d.idx = ctrl_q.idx - 1'b1;
                    end
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: ctrl_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: SEQ_IDLE, cnt: '0, idx: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy    = (ctrl_q.state == SEQ_TRIAL);
    assign bit_idx = ctrl_q.idx;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int WIDTH = 16,
    parameter int IW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             decide,
    input  logic             cmp_hi,
    input  logic [IW-1:0]    bit_idx,
    output logic [WIDTH-1:0] code,
    output logic [WIDTH-1:0] decided
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] code;
    } trial_t;

    trial_t trial_d, trial_q;

    always_comb begin
        decided = trial_q.code;
        for (int i = 0; i < WIDTH; i++) begin
            if (IW'(i) == bit_idx) begin
                decided[i] = cmp_hi;
            end
        end

        trial_d = trial_q;
        if (init) begin
            trial_d.code = MSB_ONLY;
        end else if (decide) begin
            trial_d.code = decided;
            for (int i = 0; i < WIDTH - 1; i++) begin
                if (IW'(i + 1) == bit_idx) begin
                    trial_d.code[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '{code: '0};
        end else begin
            trial_q <= trial_d;
        end
    end

    assign code = trial_q.code;

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             bipolar,
    input  logic             load,
    input  logic [WIDTH-1:0] final_code,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    localparam logic [WIDTH-1:0] SIGN_FLIP = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic             mode;
        logic             done;
        logic [WIDTH-1:0] value;
    } latch_t;

    latch_t lat_d, lat_q;

    always_comb begin
        lat_d      = lat_q;
        lat_d.done = load;
        if (init) begin
            lat_d.mode = bipolar;
        end
        if (load) begin
            lat_d.value = lat_q.mode ? (final_code ^ SIGN_FLIP) : final_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '{mode: 1'b0, done: 1'b0, value: '0};
        end else begin
            lat_q <= lat_d;
        end
    end

    assign result = lat_q.value;
    assign done   = lat_q.done;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int WIDTH  = 16,
    parameter int SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bipolar,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic          init_w;
    logic          decide_w;
    logic          last_w;
    logic [IW-1:0] idx_w;
    logic [WIDTH-1:0] decided_w;

    sar_step_ctrl #(
        .WIDTH  (WIDTH),
        .SETTLE (SETTLE),
        .IW     (IW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .init    (init_w),
        .decide  (decide_w),
        .last    (last_w),
        .bit_idx (idx_w)
    );

    sar_trial_reg #(
        .WIDTH (WIDTH),
        .IW    (IW)
    ) u_trial (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init_w),
        .decide  (decide_w),
        .cmp_hi  (cmp_hi),
        .bit_idx (idx_w),
        .code    (dac_code),
        .decided (decided_w)
    );

    sar_out_latch #(
        .WIDTH (WIDTH)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init_w),
        .bipolar    (bipolar),
        .load       (last_w),
        .final_code (decided_w),
        .result     (result),
        .done       (done)
    );

endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] dac_code,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == MSB_ONLY); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R5

    AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R6

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R3

endmodule

bind sar_sequencer sar_sequencer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_code (dac_code),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sar_sequencer_bench.sv
`timescale 1ns/1ps
module sar_sequencer_bench;
    localparam int BW = 6;
    localparam int BS = 2;
    localparam int STEP = BS + 1;
    localparam int LAT = BW * STEP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bipolar = 1'b0;
    logic [BW-1:0] vin = '0;
    logic [BW-1:0] dac_code;
    logic busy, done;
    logic [BW-1:0] result;
    logic cmp_hi;

    int n_total = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // ideal comparator: high when the input is at or above the trial level
    assign cmp_hi = (vin >= dac_code);

    sar_sequencer #(.WIDTH(BW), .SETTLE(BS)) u_sar_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bipolar  (bipolar),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    // one conversion; poke re-asserts start mid-run, flip toggles bipolar mid-run
    task automatic convert(input int v, input bit mode, input bit poke, input bit flip);
        int k;
        int b;
        int bad_trace;
        int bad_busy;
        logic [BW-1:0] tr;
        logic [BW-1:0] expv;
        @(negedge clk);
        vin = BW'(v);
        bipolar = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        bad_trace = -1;
        bad_busy = 0;
        while (!done && k < 4 * LAT) begin
            if (k % STEP == 0) begin
                b = BW - 1 - k / STEP;
                tr = (BW'(v) & ~BW'((1 << (b + 1)) - 1)) | BW'(1 << b);
                if (dac_code !== tr && bad_trace < 0) bad_trace = int'(dac_code);
            end
            if (!busy) bad_busy++;
            start = (poke && k == 5);
            if (flip && k == 3) bipolar = ~mode;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(k == LAT, "R3/R9 latency start-to-done", k, LAT);
        chk(bad_trace < 0, "R3 trial code staircase MSB->LSB", bad_trace, 0);
        chk(bad_busy == 0 && !busy, "R2 busy high only until done", bad_busy, 0);
        expv = mode ? (BW'(v) ^ BW'(1 << (BW - 1))) : BW'(v);
        if (poke) chk(result == expv, "R7 start while busy ignored", int'(result), int'(expv));
        else if (flip) chk(result == expv, "R8 mode taken at start", int'(result), int'(expv));
        else if (mode) chk(result == expv, "R8 bipolar result", int'(result), int'(expv));
        else chk(result == expv, "R4 unipolar result", int'(result), int'(expv));
    endtask

    initial begin
        logic [BW-1:0] held;
        int dones;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        chk(result == '0, "R1 result in reset", int'(result), 0);
        chk(dac_code == '0, "R1 dac_code in reset", int'(dac_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && result == '0, "R1 idle after reset", int'(busy), 0);

        // exhaustive sweep in both modes, includes zero and full scale
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < (1 << BW); v++) begin
                convert(v, m[0], 1'b0, 1'b0);
            end
        end

        // start held during conversion
        convert(37, 1'b0, 1'b1, 1'b0);
        convert((1 << BW) - 1, 1'b1, 1'b1, 1'b0);
        // polarity toggled during conversion
        convert(12, 1'b0, 1'b0, 1'b1);
        convert(50, 1'b1, 1'b0, 1'b1);
        convert(0, 1'b1, 1'b0, 1'b1);

        // result held, done single-cycle, comparator and mode churn ignored
        held = result;
        dones = 0;
        for (int i = 0; i < 20; i++) begin
            vin = BW'(i * 7);
            bipolar = i[0];
            @(negedge clk);
            if (done) dones++;
            if (result !== held) break;
        end
        chk(result == held, "R6 result held between conversions", int'(result), int'(held));
        chk(dones == 0, "R5 done single-cycle pulse", dones, 0);

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

endmodule